// File: doc/BRIEF.md
# UART interrupt identification unit

This block gathers the four interrupt causes of a classic byte-wide UART (a receive line error, a received character waiting, an empty transmit holding register and a change on the modem inputs). Each cause is held in its own pending flag until the access that services it. The flags are gated by a four-bit enable register. A fixed priority picks one cause, which the block reports in an 8-bit identification value. The block also drives a single active-high interrupt line.

A build-time parameter sets how the interrupt line behaves when a service access removes one cause while others stay pending. In level mode the line stays high throughout. In pulse mode the line drops for exactly one clock, so an edge-sensitive interrupt controller sees a fresh rising edge for each cause. The top two identification bits mirror the FIFO enable bit last written to the FIFO control register.

Top module: `uart_irq_ident`

## Requirements
- R1: A one-cycle event strobe sets its cause's pending flag. If the event and a clearing access for the same cause arrive in the same cycle, the flag stays set.
- R2: The enable register gates the causes. Enable bit 0 gates received data, bit 1 gates transmit empty, bit 2 gates line error and bit 3 gates modem change. A disabled cause neither raises the interrupt nor appears in the identification value, but its flag is kept. Writing 0 deasserts the interrupt. Writing a nonzero value while an enabled cause is pending raises it again.
- R3: Priority runs from line error (highest) through received data and transmit empty to modem change (lowest). Identification bits [3:1] report these causes as 011, 010, 001 and 000.
- R4: Identification bit 0 is 0 while any enabled cause is pending and 1 otherwise. Bits [5:4] always read 0.
- R5: Identification bits 7 and 6 both equal the FIFO enable bit (bit 0 of the FIFO control value) from the most recent FIFO control write. Both are 0 after reset.
- R6: Reading the receive buffer clears received data. Reading line status clears line error. Reading modem status clears modem change. Writing the transmit holding register clears transmit empty.
- R7: Reading the identification register clears transmit empty only when transmit empty is the cause being reported at that read.
- R8: In level mode the interrupt equals "any enabled cause pending", with no gap when one cause is serviced and others remain.
- R9: In pulse mode, a service access that clears a reported-or-enabled cause while another enabled cause remains drives the interrupt low for exactly one cycle, after which it rises again. When nothing remains, no extra pulse follows.
- R10: After reset the identification value is 0x01, the interrupt is low and the enable register is 0.
- R11: Every event strobe and register access sampled at a clock edge is visible on the outputs immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_line | input | 1 | Line error event strobe |
| ev_rxdata | input | 1 | Received data available event strobe |
| ev_txempty | input | 1 | Transmit holding register empty event strobe |
| ev_modem | input | 1 | Modem input change event strobe |
| rd_rxbuf | input | 1 | Receive buffer read strobe |
| rd_linestat | input | 1 | Line status read strobe |
| rd_modemstat | input | 1 | Modem status read strobe |
| rd_ident | input | 1 | Identification register read strobe |
| wr_txhold | input | 1 | Transmit holding register write strobe |
| wr_enable | input | 1 | Enable register write strobe |
| enable_wdata | input | 4 | Enable register write value |
| wr_fifoctl | input | 1 | FIFO control write strobe |
| fifoctl_bit0 | input | 1 | FIFO enable bit of the written FIFO control value |
| ident | output | 8 | Identification value |
| intr | output | 1 | Interrupt request, active high |

## Verification
A level-mode instance and a pulse-mode instance receive the same stimulus. A chain of single services with causes still pending separates the two line behaviours. A final service with nothing left shows that no stray pulse follows. Several overlapping patterns each pin down one rule: all four causes at once tests the priority order; an event colliding with its own clear tests set-over-clear; an identification read while a higher cause is reported tests the conditional transmit-empty clear. Partial enable masks, together with the all-zero and re-enable writes, show that masked causes are hidden but kept. FIFO control writes of both polarities show that the upper flags follow bit 0 alone.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int unsigned NSRC   = 4;
  localparam int unsigned IER_W  = 4;
  localparam int unsigned IIR_W  = 8;
  localparam int unsigned CODE_W = 3;

  // index equals priority rank: 0 is highest
  typedef enum logic [1:0] {
    SRC_LINE    = 2'd0,
    SRC_RXDATA  = 2'd1,
    SRC_TXEMPTY = 2'd2,
    SRC_MODEM   = 2'd3
  } src_e;

  // identification code of a cause: highest rank gets the largest code
  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
    return CODE_W'(NSRC - 1 - idx);
  endfunction

  // enable register bit positions to rank-ordered mask
  function automatic logic [NSRC-1:0] ier_to_mask(input logic [IER_W-1:0] ier);
    logic [NSRC-1:0] m;
    m[SRC_RXDATA]  = ier[0];
    m[SRC_TXEMPTY] = ier[1];
    m[SRC_LINE]    = ier[2];
    m[SRC_MODEM]   = ier[3];
    return m;
  endfunction

  function automatic logic [IIR_W-1:0] pack_iir(input logic fifo_on,
                                                input logic none,
                                                input logic [CODE_W-1:0] code);
    return {fifo_on, fifo_on, 2'b00, code, none};
  endfunction
endpackage

// File: rtl/irq_pend_cell.sv
module irq_pend_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o,
  output logic pend_nxt_o
);
  always_comb pend_nxt_o = set_i | (pend_o & ~clr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_nxt_o;
  end

  // R1: an event always leaves the flag set, even against a clear
  a_r1_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import uart_irq_pkg::*;
#(
  parameter int unsigned N = NSRC
) (
  input  logic [N-1:0]      act_i,
  output logic              any_o,
  output logic [CODE_W-1:0] code_o
);
  logic [N-1:0] grant;

  always_comb begin
    grant  = '0;
    code_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act_i[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        code_o   = src_code(i);
      end
    end
    any_o = |act_i;
  end

  // R3: at most one cause is reported at a time
  always_comb begin
    a_r3_grant_onehot: assert ($onehot0(grant));
  end
endmodule

// File: rtl/irq_line_shaper.sv
module irq_line_shaper #(
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_any_i,
  input  logic serviced_i,
  input  logic remain_i,
  output logic intr_o
);
  logic gap_q;

  generate
    if (PULSE_MODE) begin : g_pulse
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gap_q <= 1'b0;
        else        gap_q <= serviced_i & remain_i;
      end

      // R9: a service with causes left opens a gap in the next cycle
      a_r9_gap_after_service: assert property (@(posedge clk) disable iff (!rst_n)
        (serviced_i && remain_i) |=> !intr_o);
      // R9: the line is only low with causes pending right after such a service
      a_r9_gap_only_after_service: assert property (@(posedge clk) disable iff (!rst_n)
        (!intr_o && act_any_i) |-> $past(serviced_i && remain_i));
    end else begin : g_level
      always_comb gap_q = 1'b0;

      // R8: a service with causes left keeps the line up
      a_r8_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (serviced_i && remain_i) |=> intr_o);
    end
  endgenerate

  always_comb intr_o = act_any_i & ~gap_q;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter bit PULSE_MODE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_line,
  input  logic             ev_rxdata,
  input  logic             ev_txempty,
  input  logic             ev_modem,
  input  logic             rd_rxbuf,
  input  logic             rd_linestat,
  input  logic             rd_modemstat,
  input  logic             rd_ident,
  input  logic             wr_txhold,
  input  logic             wr_enable,
  input  logic [IER_W-1:0] enable_wdata,
  input  logic             wr_fifoctl,
  input  logic             fifoctl_bit0,
  output logic [IIR_W-1:0] ident,
  output logic             intr
);
  logic [IER_W-1:0]  ier_q, ier_nxt;
  logic              fifo_q;
  logic [NSRC-1:0]   set_v, clr_v, pend_q, pend_nxt;
  logic [NSRC-1:0]   mask_q, mask_nxt, act;
  logic              act_any, serviced, remain, tx_reported;
  logic [CODE_W-1:0] code;

  always_comb ier_nxt = wr_enable ? enable_wdata : ier_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ier_q  <= '0;
      fifo_q <= 1'b0;
    end else begin
      ier_q <= ier_nxt;
      if (wr_fifoctl) fifo_q <= fifoctl_bit0;
    end
  end

  always_comb begin
    tx_reported          = act_any & (code == src_code(SRC_TXEMPTY));
    set_v[SRC_LINE]      = ev_line;
    set_v[SRC_RXDATA]    = ev_rxdata;
    set_v[SRC_TXEMPTY]   = ev_txempty;
    set_v[SRC_MODEM]     = ev_modem;
    clr_v[SRC_LINE]      = rd_linestat;
    clr_v[SRC_RXDATA]    = rd_rxbuf;
    clr_v[SRC_TXEMPTY]   = wr_txhold | (rd_ident & tx_reported);
    clr_v[SRC_MODEM]     = rd_modemstat;
  end

  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_cell
      irq_pend_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (set_v[g]),
        .clr_i      (clr_v[g]),
        .pend_o     (pend_q[g]),
        .pend_nxt_o (pend_nxt[g])
      );
    end
  endgenerate

  always_comb begin
    mask_q   = ier_to_mask(ier_q);
    mask_nxt = ier_to_mask(ier_nxt);
    act      = pend_q & mask_q;
    serviced = |(act & clr_v & ~set_v);
    remain   = |(pend_nxt & mask_nxt);
  end

  irq_prio_enc #(.N(NSRC)) u_enc (
    .act_i  (act),
    .any_o  (act_any),
    .code_o (code)
  );

  irq_line_shaper #(.PULSE_MODE(PULSE_MODE)) u_shape (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_any_i  (act_any),
    .serviced_i (serviced),
    .remain_i   (remain),
    .intr_o     (intr)
  );

  always_comb ident = pack_iir(fifo_q, ~act_any, code);

  // R2: an all-zero enable write silences the line in the next cycle
  a_r2_zero_enable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_enable && (enable_wdata == '0)) |-> !intr);
  // R5: both upper flags follow the written FIFO enable bit
  a_r5_fifo_flags: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_fifoctl) |-> (ident[7] == $past(fifoctl_bit0)) && (ident[6] == $past(fifoctl_bit0)));
  // R6: a holding register write clears transmit empty unless re-raised
  a_r6_txhold_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_txhold && !ev_txempty) |-> !pend_q[SRC_TXEMPTY]);
  // R4: reserved identification bits stay zero
  a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ident[5:4] == 2'b00);
  // R8: in level mode the line and the idle bit always disagree
  a_r8_level_matches_ident: assert property (@(posedge clk) disable iff (!rst_n)
    (!PULSE_MODE) |-> (intr == !ident[0]));
endmodule

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  typedef struct {
    bit          pulse;
    bit          intr;
    logic [7:0]  iir;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_line = 0, ev_rxdata = 0, ev_txempty = 0, ev_modem = 0;
  logic rd_rxbuf = 0, rd_linestat = 0, rd_modemstat = 0, rd_ident = 0, wr_txhold = 0;
  logic wr_enable = 0, wr_fifoctl = 0, fifoctl_bit0 = 0;
  logic [3:0] enable_wdata = '0;
  logic [7:0] ident_l, ident_p;
  logic intr_l, intr_p;

  exp_t q[$];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_irq_ident #(.PULSE_MODE(1'b0)) u_uart_irq_ident (
    .clk(clk), .rst_n(rst_n),
    .ev_line(ev_line), .ev_rxdata(ev_rxdata), .ev_txempty(ev_txempty), .ev_modem(ev_modem),
    .rd_rxbuf(rd_rxbuf), .rd_linestat(rd_linestat), .rd_modemstat(rd_modemstat),
    .rd_ident(rd_ident), .wr_txhold(wr_txhold),
    .wr_enable(wr_enable), .enable_wdata(enable_wdata),
    .wr_fifoctl(wr_fifoctl), .fifoctl_bit0(fifoctl_bit0),
    .ident(ident_l), .intr(intr_l));

  uart_irq_ident #(.PULSE_MODE(1'b1)) u_uart_irq_ident_pulse (
    .clk(clk), .rst_n(rst_n),
    .ev_line(ev_line), .ev_rxdata(ev_rxdata), .ev_txempty(ev_txempty), .ev_modem(ev_modem),
    .rd_rxbuf(rd_rxbuf), .rd_linestat(rd_linestat), .rd_modemstat(rd_modemstat),
    .rd_ident(rd_ident), .wr_txhold(wr_txhold),
    .wr_enable(wr_enable), .enable_wdata(enable_wdata),
    .wr_fifoctl(wr_fifoctl), .fifoctl_bit0(fifoctl_bit0),
    .ident(ident_p), .intr(intr_p));

  // expected identification value: src -1 = none, 0 line, 1 rx, 2 tx, 3 modem
  function automatic logic [7:0] iir_of(input bit fifo, input int src);
    logic [7:0] v;
    v = fifo ? 8'hC0 : 8'h00;
    if (src < 0) v[0] = 1'b1;
    else         v[3:1] = 3'(3 - src);
    return v;
  endfunction

  task automatic expect2(input bit il, input bit ip, input logic [7:0] iir, input string tag);
    exp_t e;
    e.pulse = 0; e.intr = il; e.iir = iir; e.tag = tag; q.push_back(e);
    e.pulse = 1; e.intr = ip; q.push_back(e);
  endtask

  task automatic clk1();
    @(negedge clk);
    ev_line = 0; ev_rxdata = 0; ev_txempty = 0; ev_modem = 0;
    rd_rxbuf = 0; rd_linestat = 0; rd_modemstat = 0; rd_ident = 0; wr_txhold = 0;
    wr_enable = 0; wr_fifoctl = 0;
  endtask

  // monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        logic a_intr;
        logic [7:0] a_iir;
        e = q.pop_front();
        a_intr = e.pulse ? intr_p : intr_l;
        a_iir  = e.pulse ? ident_p : ident_l;
        checks++;
        if (a_intr !== e.intr || a_iir !== e.iir) begin
          failures++;
          $display("FAIL %s (%s mode): intr=%0b ident=%02h expected intr=%0b ident=%02h",
                   e.tag, e.pulse ? "pulse" : "level", a_intr, a_iir, e.intr, e.iir);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect2(0, 0, iir_of(0, -1), "R10 reset state");

    ev_line = 1; ev_rxdata = 1; ev_txempty = 1; ev_modem = 1; clk1();
    expect2(0, 0, iir_of(0, -1), "R2 all causes masked");

    wr_enable = 1; enable_wdata = 4'hF; clk1();
    expect2(1, 1, iir_of(0, 0), "R3 line error first, R11 next cycle");

    rd_linestat = 1; clk1();
    expect2(1, 0, iir_of(0, 1), "R6 line read clears, R8 level holds, R9 gap");
    clk1();
    expect2(1, 1, iir_of(0, 1), "R9 reassert after gap");

    rd_rxbuf = 1; clk1();
    expect2(1, 0, iir_of(0, 2), "R6 rx read clears, R3 tx next");
    clk1();
    expect2(1, 1, iir_of(0, 2), "R9 reassert");

    rd_ident = 1; clk1();
    expect2(1, 0, iir_of(0, 3), "R7 ident read clears reported tx");
    clk1();
    expect2(1, 1, iir_of(0, 3), "R4 pending bit low");

    ev_txempty = 1; ev_line = 1; clk1();
    expect2(1, 1, iir_of(0, 0), "R1 events set flags");
    rd_ident = 1; clk1();
    expect2(1, 1, iir_of(0, 0), "R7 ident read keeps unreported tx");
    rd_linestat = 1; clk1();
    expect2(1, 0, iir_of(0, 2), "R7 tx still pending");
    clk1();
    expect2(1, 1, iir_of(0, 2), "R9 reassert");

    wr_txhold = 1; clk1();
    expect2(1, 0, iir_of(0, 3), "R6 holding write clears tx");
    clk1();
    expect2(1, 1, iir_of(0, 3), "R9 reassert");

    wr_enable = 1; enable_wdata = 4'h0; clk1();
    expect2(0, 0, iir_of(0, -1), "R2 zero enable drops line");
    wr_enable = 1; enable_wdata = 4'h8; clk1();
    expect2(1, 1, iir_of(0, 3), "R2 re-enable raises line");

    rd_modemstat = 1; clk1();
    expect2(0, 0, iir_of(0, -1), "R6 modem read clears");
    clk1();
    expect2(0, 0, iir_of(0, -1), "R9 no pulse when nothing remains");

    wr_enable = 1; enable_wdata = 4'hF; clk1();
    expect2(0, 0, iir_of(0, -1), "R4 idle");
    ev_rxdata = 1; rd_rxbuf = 1; clk1();
    expect2(1, 1, iir_of(0, 1), "R1 set wins over clear");
    rd_rxbuf = 1; clk1();
    expect2(0, 0, iir_of(0, -1), "R6 rx cleared");

    wr_fifoctl = 1; fifoctl_bit0 = 1; clk1();
    expect2(0, 0, iir_of(1, -1), "R5 fifo flags set");
    ev_modem = 1; clk1();
    expect2(1, 1, iir_of(1, 3), "R5 flags with cause");
    rd_modemstat = 1; wr_fifoctl = 1; fifoctl_bit0 = 0; clk1();
    expect2(0, 0, iir_of(0, -1), "R5 fifo flags cleared");

    wr_enable = 1; enable_wdata = 4'h2; ev_rxdata = 1; ev_txempty = 1; clk1();
    expect2(1, 1, iir_of(0, 2), "R2 partial mask hides rx");
    wr_txhold = 1; clk1();
    expect2(0, 0, iir_of(0, -1), "R2 masked rx stays hidden");
    wr_enable = 1; enable_wdata = 4'h1; clk1();
    expect2(1, 1, iir_of(0, 1), "R2 masked rx was kept");
    rd_rxbuf = 1; clk1();
    expect2(0, 0, iir_of(0, -1), "R6 final clear");

    clk1();
    clk1();
    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule